// File: doc/BRIEF.md
# Speculative Request-Vector Routing Arbiter

This block is the routing-decision stage of a packet router. Once per clock it tries to pick one packet and one free output port for it. Candidates come from two places. The first is a shared holding queue whose scoreboard records the output port that each queued packet wants. The second is a set of input ports that present requests directly. Queued packets always win over input-port packets. While the queue is completely occupied, only queued packets can move.

The request vector is the per-port OR of the queued packets' wishes. In a plain design that vector would be built from the scoreboard and then feed the arbiter in the same cycle. Here that loop is cut by a register. The arbiter works from the vector registered at the end of the previous cycle, treating it as a guess, and commits a registered decision. One cycle later the guess is compared with the true vector, which has by then been registered. If the two disagree, the decision is dropped and a new one is made from the corrected vector, so a wrong guess costs one cycle.

A decision taken from the queue starts a route that lasts several cycles. No new decision is attempted until that route has finished. Because of this, a request that was removed a moment ago can never cause a false decision.

Top module: `route_spec_arb`

## Requirements
- R1: During reset and in the first cycle after it, dec_valid and mispredict are low and the queue holds no packets.
- R2: A queued packet whose requested output port is marked free in out_free is chosen ahead of every input-port request; such a decision carries dec_from_queue = 1, while an input-port decision carries dec_from_queue = 0.
- R3: Among queued candidates, the lowest free requested port number wins, then the lowest slot number holding that port code. Among input ports, the lowest input index whose requested port is free wins. dec_index carries the slot number or the input index, and dec_port carries the granted output port.
- R4: While all SLOTS queue slots are occupied, no input-port decision is emitted.
- R5: A decision attempted in cycle t is emitted in cycle t+1 with dec_valid high only when the vector it used equals the true request vector of cycle t. Its content then equals a non-speculative arbiter applied to the true vector, the queue state, in_req, in_port and out_free of cycle t.
- R6: When the vector used in an attempt at cycle t differs from the true vector of cycle t, mispredict is high and dec_valid is low in cycle t+1. In that same cycle the arbiter makes a fresh attempt from the registered true vector.
- R7: After a queue decision is emitted in cycle c, dec_valid stays low in cycles c+1 through c+QROUTE_CYC. The next attempt happens in cycle c+QROUTE_CYC, so the earliest following decision appears in cycle c+QROUTE_CYC+1.
- R8: An ins_valid pulse stores ins_port in the lowest-numbered free slot, and the pulse is ignored while the queue is full. An emitted queue decision frees its slot at the end of the cycle in which it is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | A packet enters the queue this cycle |
| ins_port | input | PORT_W | Output port requested by the entering packet |
| in_req | input | INPUTS | Per input port: a packet waits |
| in_port | input | INPUTS*PORT_W | Requested output port per input, input i at bits [i*PORT_W +: PORT_W] |
| out_free | input | PORTS | Per output port: able to accept a packet |
| dec_valid | output | 1 | A confirmed routing decision is presented |
| dec_from_queue | output | 1 | 1 when the packet comes from the queue, 0 when it comes from an input port |
| dec_index | output | IDX_W | Queue slot or input index of the routed packet |
| dec_port | output | PORT_W | Granted output port |
| mispredict | output | 1 | The previous attempt used a wrong vector and was cancelled |

## Verification
Every decision output appears one cycle after the cycle whose inputs and queue state produced it. A wrong guess shows up as mispredict in the cycle after the attempt, and the corrected decision follows one cycle later. The bench samples at the falling edge, after the rising edge that registered each result. A reference model advances in step with the clock. Each cycle it records the expectation for the next cycle from the true vector, and it compares that expectation with the outputs at the following falling edge. Directed sequences count exact cycle offsets for the misprediction penalty, the QROUTE_CYC route gap and the full-queue block.

// File: rtl/route_arb_pkg.sv
package route_arb_pkg;
   // Source of a routing decision as seen on dec_from_queue.
   typedef enum logic {
      SRC_PORT  = 1'b0,
      SRC_QUEUE = 1'b1
   } route_src_e;
endpackage

// File: rtl/route_pick.sv
// Lowest-index-first selector over a request vector.
module route_pick #(
   parameter int N = 8,
   parameter int W = $clog2(N)
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("route_pick: N must be at least 2");
   end

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/route_scoreboard.sv
// Queue occupancy with one requested-port code per slot.
module route_scoreboard #(
   parameter int SLOTS  = 8,
   parameter int PORTS  = 4,
   parameter int SLOT_W = $clog2(SLOTS),
   parameter int PORT_W = $clog2(PORTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ins_valid,
   input  logic [PORT_W-1:0]       ins_port,
   input  logic                    rm_valid,
   input  logic [SLOT_W-1:0]       rm_slot,
   output logic [PORTS-1:0]        true_vec,
   output logic [PORTS*SLOT_W-1:0] slot_of_port,
   output logic                    full
);
   logic [SLOTS-1:0]  occ_q;
   logic [PORT_W-1:0] code_q [SLOTS];
   logic              free_any;
   logic [SLOT_W-1:0] free_slot;

   route_pick #(.N(SLOTS), .W(SLOT_W)) u_free (
      .req (~occ_q),
      .any (free_any),
      .idx (free_slot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q <= '0;
         for (int s = 0; s < SLOTS; s++) code_q[s] <= '0;
      end else begin
         for (int s = 0; s < SLOTS; s++) begin
            if (rm_valid && rm_slot == SLOT_W'(s)) occ_q[s] <= 1'b0;
            if (ins_valid && free_any && free_slot == SLOT_W'(s)) begin
               occ_q[s]  <= 1'b1;
               code_q[s] <= ins_port;
            end
         end
      end
   end

   assign full = &occ_q;

   // One lookup per output port: does any slot want it, and which one first.
   for (genvar p = 0; p < PORTS; p++) begin : g_port
      logic [SLOTS-1:0]  want;
      logic [SLOT_W-1:0] first;
      always_comb begin
         for (int s = 0; s < SLOTS; s++) begin
            want[s] = occ_q[s] && (code_q[s] == PORT_W'(p));
         end
      end
      route_pick #(.N(SLOTS), .W(SLOT_W)) u_first (
         .req (want),
         .any (true_vec[p]),
         .idx (first)
      );
      assign slot_of_port[p*SLOT_W +: SLOT_W] = first;
   end
endmodule

// File: rtl/route_decide.sv
// Combinational decision: queue over inputs, lowest index first.
module route_decide
   import route_arb_pkg::*;
#(
   parameter int PORTS  = 4,
   parameter int INPUTS = 4,
   parameter int SLOT_W = 3,
   parameter int PORT_W = 2,
   parameter int IN_W   = 2,
   parameter int IDX_W  = 3
) (
   input  logic [PORTS-1:0]         cand_vec,
   input  logic [PORTS-1:0]         out_free,
   input  logic [PORTS*SLOT_W-1:0]  slot_of_port,
   input  logic                     q_full,
   input  logic [INPUTS-1:0]        in_req,
   input  logic [INPUTS*PORT_W-1:0] in_port,
   output logic                     hit,
   output route_src_e               src,
   output logic [IDX_W-1:0]         index,
   output logic [PORT_W-1:0]        port
);
   logic              q_any, i_any;
   logic [PORT_W-1:0] q_port;
   logic [IN_W-1:0]   i_sel;
   logic [INPUTS-1:0] in_ok;

   route_pick #(.N(PORTS), .W(PORT_W)) u_qport (
      .req (cand_vec & out_free),
      .any (q_any),
      .idx (q_port)
   );

   for (genvar i = 0; i < INPUTS; i++) begin : g_in
      assign in_ok[i] = in_req[i] & out_free[in_port[i*PORT_W +: PORT_W]];
   end

   route_pick #(.N(INPUTS), .W(IN_W)) u_inp (
      .req (in_ok),
      .any (i_any),
      .idx (i_sel)
   );

   always_comb begin
      hit   = 1'b0;
      src   = SRC_PORT;
      index = '0;
      port  = '0;
      if (q_any) begin
         hit   = 1'b1;
         src   = SRC_QUEUE;
         index = IDX_W'(slot_of_port[q_port*SLOT_W +: SLOT_W]);
         port  = q_port;
      end else if (i_any && !q_full) begin
         hit   = 1'b1;
         src   = SRC_PORT;
         index = IDX_W'(i_sel);
         port  = in_port[i_sel*PORT_W +: PORT_W];
      end
   end
endmodule

// File: rtl/route_spec_arb.sv
// Routing arbiter that decides on last cycle's request vector and
// confirms the guess one cycle later.
module route_spec_arb
   import route_arb_pkg::*;
#(
   parameter int SLOTS      = 8,
   parameter int PORTS      = 4,
   parameter int INPUTS     = 4,
   parameter int QROUTE_CYC = 3,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int PORT_W = $clog2(PORTS),
   localparam int IN_W   = $clog2(INPUTS),
   localparam int IDX_W  = (SLOT_W > IN_W) ? SLOT_W : IN_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ins_valid,
   input  logic [PORT_W-1:0]        ins_port,
   input  logic [INPUTS-1:0]        in_req,
   input  logic [INPUTS*PORT_W-1:0] in_port,
   input  logic [PORTS-1:0]         out_free,
   output logic                     dec_valid,
   output logic                     dec_from_queue,
   output logic [IDX_W-1:0]         dec_index,
   output logic [PORT_W-1:0]        dec_port,
   output logic                     mispredict
);
   localparam int HOLD_W = $clog2(QROUTE_CYC + 1);

   if (SLOTS < 2 || PORTS < 2 || INPUTS < 2) begin : g_bad_size
      $error("route_spec_arb: SLOTS, PORTS and INPUTS must be at least 2");
   end
   if (QROUTE_CYC < 2) begin : g_bad_hold
      $error("route_spec_arb: QROUTE_CYC below 2 lets a stale request be picked");
   end

   logic [PORTS-1:0]        true_vec;
   logic [PORTS*SLOT_W-1:0] slot_of_port;
   logic                    q_full;

   // Two registered copies of the true vector: one feeds the guess path,
   // the other the check and the correction path.
   logic [PORTS-1:0]  pred_q, chk_q, used_q, use_vec;
   logic              att_q, att, blk;
   logic              hit, hit_q;
   route_src_e        src, src_q;
   logic [IDX_W-1:0]  idx, idx_q;
   logic [PORT_W-1:0] prt, prt_q;
   logic [HOLD_W-1:0] hold_q;
   logic              q_route;

   route_scoreboard #(.SLOTS(SLOTS), .PORTS(PORTS)) u_sb (
      .clk          (clk),
      .rst_n        (rst_n),
      .ins_valid    (ins_valid),
      .ins_port     (ins_port),
      .rm_valid     (q_route),
      .rm_slot      (idx_q[SLOT_W-1:0]),
      .true_vec     (true_vec),
      .slot_of_port (slot_of_port),
      .full         (q_full)
   );

   // Verification of last cycle's guess, and the 2:1 vector select.
   assign mispredict     = att_q && (used_q != chk_q);
   assign dec_valid      = att_q && !mispredict && hit_q;
   assign dec_from_queue = (src_q == SRC_QUEUE);
   assign dec_index      = idx_q;
   assign dec_port       = prt_q;
   assign q_route        = dec_valid && (src_q == SRC_QUEUE);
   assign use_vec        = mispredict ? chk_q : pred_q;
   assign blk            = q_route || (hold_q != '0);
   assign att            = !blk;

   route_decide #(
      .PORTS(PORTS), .INPUTS(INPUTS), .SLOT_W(SLOT_W),
      .PORT_W(PORT_W), .IN_W(IN_W), .IDX_W(IDX_W)
   ) u_dec (
      .cand_vec     (use_vec),
      .out_free     (out_free),
      .slot_of_port (slot_of_port),
      .q_full       (q_full),
      .in_req       (in_req),
      .in_port      (in_port),
      .hit          (hit),
      .src          (src),
      .index        (idx),
      .port         (prt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_q <= '0;
         chk_q  <= '0;
         used_q <= '0;
         att_q  <= 1'b0;
         hit_q  <= 1'b0;
         src_q  <= SRC_PORT;
         idx_q  <= '0;
         prt_q  <= '0;
         hold_q <= '0;
      end else begin
         pred_q <= true_vec;
         chk_q  <= true_vec;
         used_q <= use_vec;
         att_q  <= att;
         hit_q  <= hit;
         src_q  <= src;
         idx_q  <= idx;
         prt_q  <= prt;
         if (q_route)             hold_q <= HOLD_W'(QROUTE_CYC - 1);
         else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
      end
   end
endmodule

// File: rtl/route_spec_arb_chk.sv
module route_spec_arb_chk #(
   parameter int QROUTE_CYC = 3
) (
   input logic clk,
   input logic rst_n,
   input logic dec_valid,
   input logic dec_from_queue,
   input logic mispredict,
   input logic q_full
);
   localparam int GAP_W = $clog2(QROUTE_CYC + 1);

   // Cycles since the last emitted queue decision, saturating.
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         gap_q <= GAP_W'(QROUTE_CYC);
      else if (dec_valid && dec_from_queue) gap_q <= '0;
      else if (gap_q != GAP_W'(QROUTE_CYC)) gap_q <= gap_q + 1'b1;
   end

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!dec_valid && !mispredict));

   assert_cancel_on_mispredict_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> !dec_valid);

   assert_no_back_to_back_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_from_queue) |=> !dec_valid);

   assert_route_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (gap_q == GAP_W'(QROUTE_CYC)));

   assert_no_input_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_from_queue) |-> !$past(q_full));
endmodule

bind route_spec_arb route_spec_arb_chk #(.QROUTE_CYC(QROUTE_CYC)) u_route_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .dec_valid      (dec_valid),
   .dec_from_queue (dec_from_queue),
   .mispredict     (mispredict),
   .q_full         (q_full)
);

// File: tb/test_route_spec_arb.sv
`timescale 1ns/1ps
module test_route_spec_arb;
   localparam int H = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ins_valid = 1'b0;
   logic [1:0] ins_port = '0;
   logic [3:0] in_req = '0;
   logic [7:0] in_port = '0;
   logic [3:0] out_free = '0;
   logic       dec_valid, dec_from_queue, mispredict;
   logic [2:0] dec_index;
   logic [1:0] dec_port;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   route_spec_arb #(.SLOTS(8), .PORTS(4), .INPUTS(4), .QROUTE_CYC(H)) i_route_spec_arb (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_port(ins_port),
      .in_req(in_req), .in_port(in_port), .out_free(out_free),
      .dec_valid(dec_valid), .dec_from_queue(dec_from_queue),
      .dec_index(dec_index), .dec_port(dec_port), .mispredict(mispredict)
   );

   // Reference model: scoreboard plus a non-speculative arbiter on the true vector.
   bit [7:0] m_occ;
   bit [1:0] m_code [8];
   bit [3:0] m_prev;
   int       m_cnt;
   bit       e_valid, e_mis, e_fq;
   bit [2:0] e_idx;
   bit [1:0] e_port;

   // {ins_valid, ins_port, in_req, in_port, out_free}
   localparam logic [18:0] STIM [16] = '{
      {1'b0, 2'd0, 4'b0000, 8'h00, 4'b1111},
      {1'b0, 2'd0, 4'b0001, 8'h00, 4'b1111},
      {1'b0, 2'd0, 4'b0110, 8'b00111000, 4'b1100},
      {1'b1, 2'd2, 4'b0000, 8'h00, 4'b0000},
      {1'b1, 2'd1, 4'b0000, 8'h00, 4'b0000},
      {1'b1, 2'd1, 4'b0001, 8'h00, 4'b0001},
      {1'b0, 2'd0, 4'b0001, 8'h00, 4'b0111},
      {1'b0, 2'd0, 4'b0011, 8'h04, 4'b0111},
      {1'b0, 2'd0, 4'b0011, 8'h04, 4'b0111},
      {1'b0, 2'd0, 4'b0011, 8'h04, 4'b0111},
      {1'b1, 2'd0, 4'b1111, 8'hE4, 4'b1111},
      {1'b1, 2'd3, 4'b1111, 8'hE4, 4'b1000},
      {1'b0, 2'd0, 4'b1000, 8'hC0, 4'b1000},
      {1'b0, 2'd0, 4'b0000, 8'h00, 4'b1111},
      {1'b1, 2'd2, 4'b0010, 8'h04, 4'b0110},
      {1'b0, 2'd0, 4'b0010, 8'h04, 4'b0110}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit [3:0] true_vec();
      bit [3:0] v = '0;
      for (int s = 0; s < 8; s++) if (m_occ[s]) v[m_code[s]] = 1'b1;
      return v;
   endfunction

   task automatic model_reset();
      m_occ = '0; m_prev = '0; m_cnt = 0;
      e_valid = 0; e_mis = 0; e_fq = 0; e_idx = '0; e_port = '0;
      for (int s = 0; s < 8; s++) m_code[s] = '0;
   endtask

   // Called at a falling edge: check this cycle, drive inputs, advance model, next cycle.
   task automatic step(input logic [18:0] row);
      bit [3:0] v, qc;
      bit       blocked, r_hit, r_fq, n_mis, placed;
      bit [2:0] r_idx;
      bit [1:0] r_port;
      check(dec_valid === e_valid, "R5 dec_valid", dec_valid, e_valid);
      check(mispredict === e_mis, "R6 mispredict", mispredict, e_mis);
      if (e_valid && dec_valid) begin
         check(dec_from_queue === e_fq, "R2 source", dec_from_queue, e_fq);
         check({dec_index, dec_port} === {e_idx, e_port}, "R3 R8 index/port",
               {dec_index, dec_port}, {e_idx, e_port});
      end
      ins_valid = row[18]; ins_port = row[17:16]; in_req = row[15:12];
      in_port = row[11:4]; out_free = row[3:0];
      v = true_vec();
      blocked = (e_valid && e_fq) || (m_cnt != 0);
      r_hit = 0; r_fq = 0; r_idx = '0; r_port = '0;
      qc = v & out_free;
      if (qc != 0) begin
         for (int p = 3; p >= 0; p--) if (qc[p]) r_port = 2'(p);
         for (int s = 7; s >= 0; s--) if (m_occ[s] && m_code[s] == r_port) r_idx = 3'(s);
         r_hit = 1; r_fq = 1;
      end else if (m_occ != 8'hFF) begin
         for (int i = 3; i >= 0; i--) begin
            if (in_req[i] && out_free[in_port[i*2 +: 2]]) begin
               r_hit = 1; r_idx = 3'(i); r_port = in_port[i*2 +: 2];
            end
         end
      end
      n_mis = !blocked && (m_prev != v);
      if (e_valid && e_fq) m_cnt = H - 1;
      else if (m_cnt > 0) m_cnt--;
      if (ins_valid && m_occ != 8'hFF) begin
         placed = 0;
         for (int s = 0; s < 8; s++) begin
            if (!placed && !m_occ[s]) begin
               m_occ[s] = 1'b1; m_code[s] = ins_port; placed = 1;
            end
         end
      end
      if (e_valid && e_fq) m_occ[e_idx] = 1'b0;
      m_prev  = v;
      e_mis   = n_mis;
      e_valid = !blocked && !n_mis && r_hit;
      e_fq = r_fq; e_idx = r_idx; e_port = r_port;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ins_valid = 0; in_req = '0; in_port = '0; out_free = '0; ins_port = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(dec_valid === 1'b0 && mispredict === 1'b0, "R1 outputs in reset",
            {dec_valid, mispredict}, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      bit lv [8];
      bit lq [8];
      bit lm [8];
      int nvalid;
      do_reset();
      check(dec_valid === 1'b0 && mispredict === 1'b0, "R1 outputs after reset",
            {dec_valid, mispredict}, 0);

      // Table walk: model compares every cycle.
      for (int k = 0; k < 16; k++) step(STIM[k]);
      for (int k = 0; k < 8; k++) step({1'b0, 2'd0, 4'b0000, 8'h00, 4'b1111});

      // Misprediction penalty and queue route gap (R6, R2, R7).
      do_reset();
      step({1'b1, 2'd2, 4'b0001, 8'h00, 4'b1111});
      lv[0] = dec_valid; lq[0] = dec_from_queue; lm[0] = mispredict;
      for (int k = 1; k < 8; k++) begin
         step({1'b0, 2'd0, 4'b0001, 8'h00, 4'b1111});
         lv[k] = dec_valid; lq[k] = dec_from_queue; lm[k] = mispredict;
      end
      check(lv[0] && !lq[0], "R5 input decision before insert is seen", {lv[0], lq[0]}, 2'b10);
      check(lm[1] && !lv[1], "R6 stale vector cancelled", {lm[1], lv[1]}, 2'b10);
      check(lv[2] && lq[2], "R2 redo picks queued packet", {lv[2], lq[2]}, 2'b11);
      check(!lv[3] && !lv[4] && !lv[5], "R7 no decision during route",
            {lv[3], lv[4], lv[5]}, 0);
      check(lv[6], "R7 decision resumes after route", lv[6], 1);

      // Full queue blocks input ports (R4), then queue drains (R2).
      do_reset();
      for (int k = 0; k < 8; k++) step({1'b1, 2'd0, 4'b0000, 8'h00, 4'b0000});
      nvalid = 0;
      for (int k = 0; k < 6; k++) begin
         step({1'b0, 2'd0, 4'b0001, 8'h01, 4'b0010});
         if (dec_valid) nvalid++;
      end
      check(nvalid == 0, "R4 input blocked while full", nvalid, 0);
      step({1'b1, 2'd3, 4'b0001, 8'h01, 4'b0010});
      for (int k = 0; k < 3; k++) step({1'b0, 2'd0, 4'b0001, 8'h01, 4'b0011});
      for (int k = 0; k < 10; k++) step({1'b0, 2'd0, 4'b0001, 8'h01, 4'b0010});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      errors++;
      $display("FAIL R5 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule